// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus. Software picks a reload value and a clock divider, enables the timer, and must keep writing a fixed restart value before the counter runs out. If the counter reaches zero while the timer is enabled, a sticky timeout flag is raised. The flag can drive a level interrupt, a one-shot reset pulse of selectable length, or both.

Each configuration write must carry a register-specific key field, or it is dropped. This guards the timer against stray stores. The counter holds a 12-bit reload value in its upper bits and zeros in its lower `FRAC_W` bits. It decrements once per divided clock tick. Clearing the enable bit freezes the counter and the divider where they stand.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `irq_o` and `rst_o` are low. Word 0 reads 0x0, word 1 reads 0x3FFC (reload 0xFFF, divider select 0), and word 3 reads 0x0.
- R2: A write to word 0 is applied only when bits [23:12] equal 0xABC. Its fields are: bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, bits [5:4] pulse length. Any other key leaves the register unchanged.
- R3: A write to word 1 is applied only when bits [25:14] equal 0x248. Bits [13:2] hold the reload value and bits [1:0] the divider select. Any other key leaves the register unchanged.
- R4: Reads return only the stored fields, at the positions given in R2 and R3, with every key bit read as zero. Word 2 always reads zero. Word 3 returns the timeout flag in bit 0.
- R5: Writing exactly 0x00001999 to word 2 does three things: it loads the counter with reload × 2^FRAC_W, restarts the divider and clears the flag. Any other value written to word 2 has no effect.
- R6: Divider select values 0, 1, 2 and 3 divide by 8, 64, 512 and 4096. With the timer enabled, the flag reads 1 from the (K+1)th clock edge after the restart edge, where K = reload × 2^FRAC_W × divisor.
- R7: The flag is set when the enabled counter is zero. It then stays set until the next valid restart.
- R8: `irq_o` is high exactly while the flag is set and the interrupt enable bit is 1.
- R9: When the flag becomes set and the reset-output enable bit is 1, `rst_o` goes high once for 2, 4, 8 or 16 cycles, for pulse-length codes 0 to 3. When that bit is 0, `rst_o` stays low.
- R10: While the enable bit is 0, the counter and the divider hold their values and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word address: 0 mode, 1 counter control, 2 restart, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Timeout interrupt level |
| rst_o | output | 1 | Timeout reset pulse |

## Verification
The bench checks the exact timeout edge for all four divider selects and two reload values. A design that counts one tick too many or too few, or that scales the reload value wrongly, therefore misses the sampled window. Writes with a wrong key, and restart values off by one, are sent to each register; a design that matches only part of a key, or accepts a near-miss restart value, changes state that the bench reads back. The reset pulse is counted cycle by cycle for several length codes and with its enable cleared, which exposes an off-by-one pulse length or a pulse that retriggers. A mid-count disable must leave the flag clear, which catches a divider or counter that keeps running while the timer is off.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int FRAC_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        rst_o
);
  localparam int RLD_W = 12;
  localparam int CNT_W = RLD_W + FRAC_W;
  localparam logic [11:0] MODE_KEY = 12'hABC;
  localparam logic [11:0] CTRL_KEY = 12'h248;
  localparam logic [31:0] KICK_VAL = 32'h0000_1999;

  logic             en, rst_en, irq_en;
  logic [1:0]       plen_sel, dsel;
  logic [RLD_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic [12:0]      div, div_lim;
  logic             flag;
  logic [4:0]       pulse;

  wire mode_hit = bus_we && bus_addr == 2'd0 && bus_wdata[23:12] == MODE_KEY;
  wire ctrl_hit = bus_we && bus_addr == 2'd1 && bus_wdata[25:14] == CTRL_KEY;
  wire kick     = bus_we && bus_addr == 2'd2 && bus_wdata == KICK_VAL;

  assign div_lim = (13'd8 << (4'(dsel) * 4'd3)) - 13'd1;
  wire tick     = en && div == div_lim;
  wire flag_set = en && !flag && !kick && cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, rst_en, irq_en} <= 3'b000;
      plen_sel <= 2'd0;
    end else if (mode_hit) begin
      {irq_en, rst_en, en} <= bus_wdata[2:0];
      plen_sel <= bus_wdata[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '1;
      dsel   <= 2'd0;
    end else if (ctrl_hit) begin
      reload <= bus_wdata[13:2];
      dsel   <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= {RLD_W'('1), FRAC_W'(0)};
      div  <= '0;
      flag <= 1'b0;
    end else if (kick) begin
      cnt  <= {reload, FRAC_W'(0)};
      div  <= '0;
      flag <= 1'b0;
    end else begin
      if (en) begin
        if (tick) begin
          div <= '0;
          if (cnt != '0) cnt <= cnt - 1'b1;
        end else begin
          div <= div + 1'b1;
        end
      end
      if (flag_set) flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pulse <= '0;
    else if (flag_set && rst_en) pulse <= 5'd2 << plen_sel;
    else if (pulse != '0)        pulse <= pulse - 1'b1;
  end

  assign irq_o = flag && irq_en;
  assign rst_o = pulse != '0;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {26'd0, plen_sel, 1'b0, irq_en, rst_en, en};
      2'd1:    bus_rdata = {18'd0, reload, dsel};
      2'd2:    bus_rdata = 32'd0;
      default: bus_rdata = {31'd0, flag};
    endcase
  end

  AST_MODE_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0 && bus_wdata[23:12] != MODE_KEY) |=> $stable({en, rst_en, irq_en, plen_sel})); // R2
  AST_CTRL_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1 && bus_wdata[25:14] != CTRL_KEY) |=> $stable({reload, dsel})); // R3
  AST_KICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == {$past(reload), FRAC_W'(0)} && !flag)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !kick) |=> flag); // R7
  AST_PULSE_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $rose(flag)); // R9
  AST_HALT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !kick) |=> ($stable(cnt) && $stable(div) && !$rose(flag))); // R10
endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;
  localparam int FRAC = 4;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic irq_o, rst_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [33:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  wdt_keyed #(.FRAC_W(FRAC)) uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_o(rst_o));

  function automatic logic [31:0] md(input logic [1:0] pl, input logic ie, re, en);
    return 32'h00AB_C000 | {26'd0, pl, 1'b0, ie, re, en};
  endfunction
  function automatic logic [31:0] cc(input logic [11:0] rv, input logic [1:0] ds);
    return 32'h0092_0000 | {18'd0, rv, ds};
  endfunction

  task automatic score(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with outputs mid-cycle
  initial forever begin
    @(negedge clk); #5;
    while (exp_q.size() > 0) begin
      logic [33:0] it;
      string tg;
      it = exp_q.pop_front();
      tg = tag_q.pop_front();
      case (it[33:32])
        2'd0:    score(tg, bus_rdata, it[31:0]);
        2'd1:    score(tg, {31'd0, irq_o}, it[31:0]);
        default: score(tg, {31'd0, rst_o}, it[31:0]);
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask
  task automatic exp_rd(input string tag, input logic [1:0] a, input logic [31:0] e);
    bus_addr = a; exp_q.push_back({2'd0, e}); tag_q.push_back(tag);
    @(negedge clk);
  endtask
  task automatic exp_pin(input string tag, input logic [1:0] k, input logic e);
    exp_q.push_back({k, 31'd0, e}); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic timeout_run(input string tag, input logic [11:0] rv, input logic [1:0] ds);
    int k;
    k = int'(rv) * (1 << FRAC) * (8 << (3 * ds));
    wr(2'd1, cc(rv, ds));
    wr(2'd2, 32'h1999);
    repeat (k - 2) @(negedge clk);
    exp_rd({tag, " before"}, 2'd3, 32'd0);
    repeat (2) @(negedge clk);
    exp_rd({tag, " after"}, 2'd3, 32'd1);
  endtask

  task automatic pulse_run(input string tag, input logic [1:0] pl, input logic re, input int exp_len);
    int hi;
    hi = 0;
    wr(2'd0, md(pl, 1'b0, re, 1'b1));
    wr(2'd2, 32'h1999);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rst_o) hi++;
    end
    score(tag, hi, exp_len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_rd("R1 mode reset", 2'd0, 32'h0);
    exp_rd("R1 ctrl reset", 2'd1, 32'h3FFC);
    exp_rd("R1 status reset", 2'd3, 32'h0);
    exp_pin("R1 irq reset", 2'd1, 1'b0);
    exp_pin("R1 rst reset", 2'd2, 1'b0);

    wr(2'd0, 32'h00AB_D007);
    exp_rd("R2 bad key ignored", 2'd0, 32'h0);
    wr(2'd0, md(2'd2, 1'b1, 1'b0, 1'b0));
    exp_rd("R2 R4 mode fields", 2'd0, 32'h24);
    wr(2'd1, 32'h0093_0005);
    exp_rd("R3 bad key ignored", 2'd1, 32'h3FFC);
    wr(2'd1, cc(12'h5A5, 2'd2));
    exp_rd("R3 R4 ctrl fields", 2'd1, 32'h1696);
    exp_rd("R4 restart reads zero", 2'd2, 32'h0);

    wr(2'd0, md(2'd0, 1'b1, 1'b0, 1'b1));
    timeout_run("R6 div8 reload2", 12'd2, 2'd0);
    exp_pin("R8 irq high on flag", 2'd1, 1'b1);
    timeout_run("R6 div64", 12'd1, 2'd1);
    timeout_run("R6 div512", 12'd1, 2'd2);
    timeout_run("R6 div4096", 12'd1, 2'd3);

    wr(2'd2, 32'h1998);
    exp_rd("R5 wrong restart value", 2'd3, 32'd1);
    repeat (50) @(negedge clk);
    exp_rd("R7 flag sticky", 2'd3, 32'd1);
    wr(2'd0, md(2'd0, 1'b0, 1'b0, 1'b1));
    exp_pin("R8 irq masked", 2'd1, 1'b0);
    wr(2'd0, md(2'd0, 1'b1, 1'b0, 1'b1));
    exp_pin("R8 irq unmasked", 2'd1, 1'b1);

    wr(2'd1, cc(12'd1, 2'd0));
    wr(2'd2, 32'h1999);
    exp_rd("R5 restart clears flag", 2'd3, 32'd0);
    exp_pin("R8 irq low after restart", 2'd1, 1'b0);
    repeat (60) @(negedge clk);
    wr(2'd0, md(2'd0, 1'b1, 1'b0, 1'b0));
    repeat (300) @(negedge clk);
    exp_rd("R10 no timeout while off", 2'd3, 32'd0);
    wr(2'd0, md(2'd0, 1'b1, 1'b0, 1'b1));
    repeat (100) @(negedge clk);
    exp_rd("R10 resumes when on", 2'd3, 32'd1);

    wr(2'd1, cc(12'd0, 2'd0));
    pulse_run("R9 pulse len 2", 2'd0, 1'b1, 2);
    pulse_run("R9 pulse len 4", 2'd1, 1'b1, 4);
    pulse_run("R9 pulse len 16", 2'd3, 1'b1, 16);
    pulse_run("R9 pulse disabled", 2'd3, 1'b0, 0);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule